// File: doc/BRIEF.md
# Corrector Override Confidence Chooser

This block sits after a base branch direction predictor and a statistical corrector. It decides whether the final direction follows the base prediction or the corrector. The corrector's signed sum is formed inside the block. An externally supplied partial sum (for example a bias term) is added to one odd contribution `2*w+1` from each of the corrector's weight tables. The sign of the sum gives the corrector's direction. Its magnitude, compared against a run-time threshold, gives the confidence.

When the two directions disagree, the magnitude falls into one of four confidence bands. The bands are: below a third of the threshold, below two thirds of it, below the threshold, and at or above it. In the top band the corrector always wins. Each of the three lower bands owns a small signed chooser counter. The corrector overrides only while that counter is negative. The prediction path is purely combinational.

At branch resolution a one-cycle update strobe brings in the saved sum, threshold, base direction, actual outcome and the weights that were read. The strobe is registered. In the following cycle the block presents the trained weights together with a write enable, and the chooser counter of the band concerned is committed on the next clock edge.

Top module: `corrector_chooser`

## Requirements
- R1: The corrector direction `pred_sc_dir` is 1 (taken) when the signed sum is greater than or equal to zero, and 0 otherwise.
- R2: When the base direction equals the corrector direction, `pred_final_dir` equals the base direction.
- R3: On disagreement with magnitude below `thresh/3` (band code 0), the output follows the corrector only while the band 0 chooser counter is negative, and follows the base otherwise.
- R4: Band code 1 covers magnitudes from `thresh/3` up to but excluding `(2*thresh)/3`. Band code 2 covers the range from there up to but excluding `thresh`. Each band applies the rule of R3 with its own counter. `pred_band` reports the band code, with 3 meaning at or above the threshold.
- R5: On disagreement with magnitude at or above the threshold (band code 3), the output follows the corrector.
- R6: `pred_sum` equals `pred_bias_sum` plus `2*w+1` for every signed weight `w`. Table i occupies bits `[i*WEIGHT_W +: WEIGHT_W]` of `pred_weights`.
- R7: One cycle after an update strobe, `wt_we` is 1 exactly when the saved corrector direction differed from the outcome or the saved magnitude was below the saved threshold. Without a strobe, `wt_we` is 0.
- R8: Trained weights move by one toward the outcome: up on taken, down on not taken. They saturate at `-(2^(WEIGHT_W-1))` and `2^(WEIGHT_W-1)-1`.
- R9: A chooser counter changes only on an update whose base and corrector directions disagree with the saved magnitude inside its own band. It moves down when the corrector matched the outcome and up when the base did.
- R10: Chooser counters saturate at `-(2^(CHOOSER_W-1))` and `2^(CHOOSER_W-1)-1` without wrapping.
- R11: After reset all chooser counters are zero, so a disagreement in any lower band keeps the base direction, and `wt_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_base_dir | input | 1 | Base predictor direction |
| pred_bias_sum | input | SUM_W | Signed partial sum added before table contributions |
| pred_weights | input | NUM_TABLES*WEIGHT_W | Signed weights read for this branch |
| pred_thresh | input | THR_W | Confidence threshold |
| pred_final_dir | output | 1 | Chosen final direction |
| pred_sc_dir | output | 1 | Corrector direction |
| pred_sum | output | SUM_W | Signed corrector sum |
| pred_band | output | 2 | Confidence band code |
| upd_valid | input | 1 | Update strobe |
| upd_base_dir | input | 1 | Saved base direction |
| upd_sum | input | SUM_W | Saved signed sum |
| upd_thresh | input | THR_W | Saved threshold |
| upd_taken | input | 1 | Resolved outcome |
| upd_weights | input | NUM_TABLES*WEIGHT_W | Weights read at prediction time |
| wt_we | output | 1 | Trained weights are to be written |
| wt_new | output | NUM_TABLES*WEIGHT_W | Trained weights |

## Verification
The bench builds the block with four tables of 6-bit weights, a 12-bit sum, a 10-bit threshold and 3-bit chooser counters. The narrow chooser counters reach both saturation limits within half a dozen updates, so a wrapping counter would flip the observed override decision. The 6-bit weights are loaded at their extremes, so a single training step shows saturation. A threshold of 30 gives band limits of 10 and 20, which puts sums of 5, 15, 25 and 35 cleanly in each band.

// File: rtl/scoc_pkg.sv
package scoc_pkg;

    typedef enum logic [1:0] {
        BAND_LOW    = 2'd0,
        BAND_MID    = 2'd1,
        BAND_HIGH   = 2'd2,
        BAND_BEYOND = 2'd3
    } band_e;

    localparam int NUM_BANDS = 3;

    function automatic logic is_lower_band(input band_e b);
        return b != BAND_BEYOND;
    endfunction

endpackage

// File: rtl/scoc_sum_accum.sv
module scoc_sum_accum #(
    parameter int NUM_TABLES = 4,
    parameter int WEIGHT_W   = 6,
    parameter int SUM_W      = 12
) (
    input  logic signed [SUM_W-1:0]             bias_sum,
    input  logic [NUM_TABLES*WEIGHT_W-1:0]      weights,
    output logic signed [SUM_W-1:0]             sum
);
    localparam int EXT_W = SUM_W - WEIGHT_W - 1;

    logic signed [SUM_W-1:0] contrib [NUM_TABLES];

    for (genvar i = 0; i < NUM_TABLES; i++) begin : g_contrib
        logic [WEIGHT_W-1:0] w;
        assign w = weights[i*WEIGHT_W +: WEIGHT_W];
        // odd contribution 2*w+1, sign-extended
        assign contrib[i] = {{EXT_W{w[WEIGHT_W-1]}}, w, 1'b1};
    end

    always_comb begin
        sum = bias_sum;
        for (int i = 0; i < NUM_TABLES; i++) begin
            sum = sum + contrib[i];
        end
    end
endmodule

// File: rtl/scoc_band_classify.sv
module scoc_band_classify
    import scoc_pkg::*;
#(
    parameter int SUM_W = 12,
    parameter int THR_W = 10
) (
    input  logic signed [SUM_W-1:0] sum,
    input  logic [THR_W-1:0]        thresh,
    output logic                    sc_dir,
    output band_e                   band
);
    localparam int CMP_W = (SUM_W > THR_W + 1) ? SUM_W : THR_W + 1;

    localparam logic [THR_W-1:0] THREE_N = THR_W'(3);
    localparam logic [THR_W:0]   THREE_W = (THR_W + 1)'(3);

    logic [SUM_W-1:0] neg_sum;
    logic [CMP_W-1:0] mag;
    logic [CMP_W-1:0] lim_low;
    logic [CMP_W-1:0] lim_mid;
    logic [CMP_W-1:0] lim_full;
    logic [THR_W:0]   thr_x2;

    assign sc_dir  = ~sum[SUM_W-1];
    assign neg_sum = ~sum + 1'b1;
    assign mag     = sum[SUM_W-1] ? CMP_W'(neg_sum) : CMP_W'(sum);

    assign thr_x2   = {thresh, 1'b0};
    assign lim_low  = CMP_W'(thresh / THREE_N);
    assign lim_mid  = CMP_W'(thr_x2 / THREE_W);
    assign lim_full = CMP_W'(thresh);

    always_comb begin
        if (mag < lim_low)       band = BAND_LOW;
        else if (mag < lim_mid)  band = BAND_MID;
        else if (mag < lim_full) band = BAND_HIGH;
        else                     band = BAND_BEYOND;
    end
endmodule

// File: rtl/scoc_chooser_bank.sv
module scoc_chooser_bank
    import scoc_pkg::*;
#(
    parameter int CHOOSER_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              upd_en,
    input  band_e                             upd_band,
    input  logic                              toward_neg,
    output logic [NUM_BANDS-1:0]              band_neg,
    output logic [NUM_BANDS*CHOOSER_W-1:0]    ctr_flat
);
    localparam logic signed [CHOOSER_W-1:0] CTR_MIN = {1'b1, {(CHOOSER_W-1){1'b0}}};
    localparam logic signed [CHOOSER_W-1:0] CTR_MAX = {1'b0, {(CHOOSER_W-1){1'b1}}};

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        logic signed [CHOOSER_W-1:0] ctr;
        logic                        hit;

        assign hit = upd_en && (upd_band == band_e'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctr <= '0;
            end else if (hit) begin
                if (toward_neg) begin
                    if (ctr != CTR_MIN) ctr <= ctr - 1'b1;
                end else begin
                    if (ctr != CTR_MAX) ctr <= ctr + 1'b1;
                end
            end
        end

        assign band_neg[b] = ctr[CHOOSER_W-1];
        assign ctr_flat[b*CHOOSER_W +: CHOOSER_W] = ctr;
    end
endmodule

// File: rtl/scoc_weight_trainer.sv
module scoc_weight_trainer
    import scoc_pkg::*;
#(
    parameter int NUM_TABLES = 4,
    parameter int WEIGHT_W   = 6
) (
    input  logic                           en,
    input  logic                           taken,
    input  logic                           sc_dir,
    input  band_e                          band,
    input  logic [NUM_TABLES*WEIGHT_W-1:0] weights_in,
    output logic                           we,
    output logic [NUM_TABLES*WEIGHT_W-1:0] weights_out
);
    localparam logic signed [WEIGHT_W-1:0] W_MIN = {1'b1, {(WEIGHT_W-1){1'b0}}};
    localparam logic signed [WEIGHT_W-1:0] W_MAX = {1'b0, {(WEIGHT_W-1){1'b1}}};

    assign we = en && ((sc_dir != taken) || is_lower_band(band));

    for (genvar i = 0; i < NUM_TABLES; i++) begin : g_tab
        logic signed [WEIGHT_W-1:0] w_old;
        logic signed [WEIGHT_W-1:0] w_nxt;
        assign w_old = weights_in[i*WEIGHT_W +: WEIGHT_W];

        always_comb begin
            w_nxt = w_old;
            if (taken) begin
                if (w_old != W_MAX) w_nxt = w_old + 1'b1;
            end else begin
                if (w_old != W_MIN) w_nxt = w_old - 1'b1;
            end
        end

        assign weights_out[i*WEIGHT_W +: WEIGHT_W] = w_nxt;
    end
endmodule

// File: rtl/corrector_chooser.sv
module corrector_chooser
    import scoc_pkg::*;
#(
    parameter int NUM_TABLES = 4,
    parameter int WEIGHT_W   = 6,
    parameter int SUM_W      = 12,
    parameter int THR_W      = 10,
    parameter int CHOOSER_W  = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pred_base_dir,
    input  logic [SUM_W-1:0]               pred_bias_sum,
    input  logic [NUM_TABLES*WEIGHT_W-1:0] pred_weights,
    input  logic [THR_W-1:0]               pred_thresh,
    output logic                           pred_final_dir,
    output logic                           pred_sc_dir,
    output logic [SUM_W-1:0]               pred_sum,
    output logic [1:0]                     pred_band,
    input  logic                           upd_valid,
    input  logic                           upd_base_dir,
    input  logic [SUM_W-1:0]               upd_sum,
    input  logic [THR_W-1:0]               upd_thresh,
    input  logic                           upd_taken,
    input  logic [NUM_TABLES*WEIGHT_W-1:0] upd_weights,
    output logic                           wt_we,
    output logic [NUM_TABLES*WEIGHT_W-1:0] wt_new
);
    localparam int WVEC_W = NUM_TABLES * WEIGHT_W;

    // ---------------- prediction path (combinational) ----------------
    logic signed [SUM_W-1:0] p_sum;
    band_e                   p_band;
    logic                    p_sc;
    logic [NUM_BANDS-1:0]    band_neg;

    scoc_sum_accum #(
        .NUM_TABLES(NUM_TABLES), .WEIGHT_W(WEIGHT_W), .SUM_W(SUM_W)
    ) u_accum (
        .bias_sum(pred_bias_sum),
        .weights (pred_weights),
        .sum     (p_sum)
    );

    scoc_band_classify #(.SUM_W(SUM_W), .THR_W(THR_W)) u_pred_cls (
        .sum   (p_sum),
        .thresh(pred_thresh),
        .sc_dir(p_sc),
        .band  (p_band)
    );

    always_comb begin
        if (p_sc == pred_base_dir) begin
            pred_final_dir = pred_base_dir;
        end else begin
            unique case (p_band)
                BAND_LOW:  pred_final_dir = band_neg[0] ? p_sc : pred_base_dir;
                BAND_MID:  pred_final_dir = band_neg[1] ? p_sc : pred_base_dir;
                BAND_HIGH: pred_final_dir = band_neg[2] ? p_sc : pred_base_dir;
                default:   pred_final_dir = p_sc;
            endcase
        end
    end

    assign pred_sc_dir = p_sc;
    assign pred_sum    = p_sum;
    assign pred_band   = p_band;

    // ---------------- update path (registered strobe) ----------------
    logic                    uq_valid;
    logic                    uq_base;
    logic                    uq_taken;
    logic signed [SUM_W-1:0] uq_sum;
    logic [THR_W-1:0]        uq_thr;
    logic [WVEC_W-1:0]       uq_w;

    always_ff @(posedge clk) begin
        if (rst) uq_valid <= 1'b0;
        else     uq_valid <= upd_valid;
    end

    always_ff @(posedge clk) begin
        if (upd_valid) begin
            uq_base  <= upd_base_dir;
            uq_taken <= upd_taken;
            uq_sum   <= upd_sum;
            uq_thr   <= upd_thresh;
            uq_w     <= upd_weights;
        end
    end

    band_e u_band;
    logic  u_sc;

    scoc_band_classify #(.SUM_W(SUM_W), .THR_W(THR_W)) u_upd_cls (
        .sum   (uq_sum),
        .thresh(uq_thr),
        .sc_dir(u_sc),
        .band  (u_band)
    );

    logic                            chooser_en;
    logic [NUM_BANDS*CHOOSER_W-1:0]  chooser_flat;

    assign chooser_en = uq_valid && (u_sc != uq_base) && is_lower_band(u_band);

    scoc_chooser_bank #(.CHOOSER_W(CHOOSER_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (chooser_en),
        .upd_band  (u_band),
        .toward_neg(u_sc == uq_taken),
        .band_neg  (band_neg),
        .ctr_flat  (chooser_flat)
    );

    scoc_weight_trainer #(.NUM_TABLES(NUM_TABLES), .WEIGHT_W(WEIGHT_W)) u_train (
        .en         (uq_valid),
        .taken      (uq_taken),
        .sc_dir     (u_sc),
        .band       (u_band),
        .weights_in (uq_w),
        .we         (wt_we),
        .weights_out(wt_new)
    );
endmodule

// File: rtl/scoc_checker.sv
module scoc_checker #(
    parameter int SUM_W     = 12,
    parameter int CHOOSER_W = 6,
    parameter int NUM_BANDS = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           pred_base_dir,
    input logic                           pred_sc_dir,
    input logic                           pred_final_dir,
    input logic [SUM_W-1:0]               pred_sum,
    input logic [1:0]                     pred_band,
    input logic                           upd_valid,
    input logic                           uq_valid,
    input logic                           wt_we,
    input logic [NUM_BANDS*CHOOSER_W-1:0] chooser_flat
);
    a_r1_sign_gives_dir: assert property (@(posedge clk) disable iff (rst)
        pred_sc_dir == ~pred_sum[SUM_W-1]);

    a_r2_agree_keeps_base: assert property (@(posedge clk) disable iff (rst)
        (pred_base_dir == pred_sc_dir) |-> (pred_final_dir == pred_base_dir));

    a_r5_beyond_uses_corrector: assert property (@(posedge clk) disable iff (rst)
        (pred_band == 2'd3) |-> (pred_final_dir == pred_sc_dir));

    a_r7_write_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        wt_we |-> $past(upd_valid));

    a_r9_chooser_holds_idle: assert property (@(posedge clk) disable iff (rst)
        !uq_valid |=> $stable(chooser_flat));
endmodule

bind corrector_chooser scoc_checker #(
    .SUM_W(SUM_W), .CHOOSER_W(CHOOSER_W), .NUM_BANDS(scoc_pkg::NUM_BANDS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pred_base_dir (pred_base_dir),
    .pred_sc_dir   (pred_sc_dir),
    .pred_final_dir(pred_final_dir),
    .pred_sum      (pred_sum),
    .pred_band     (pred_band),
    .upd_valid     (upd_valid),
    .uq_valid      (uq_valid),
    .wt_we         (wt_we),
    .chooser_flat  (chooser_flat)
);

// File: tb/sim_corrector_chooser.sv
module sim_corrector_chooser;
    localparam int NT = 4, WW = 6, SW = 12, TW = 10, CW = 3;
    localparam int THR = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pred_base_dir = 1'b0;
    logic [SW-1:0] pred_bias_sum = '0;
    logic [NT*WW-1:0] pred_weights = '0;
    logic [TW-1:0] pred_thresh = TW'(THR);
    logic pred_final_dir, pred_sc_dir;
    logic [SW-1:0] pred_sum;
    logic [1:0] pred_band;
    logic upd_valid = 1'b0, upd_base_dir = 1'b0, upd_taken = 1'b0;
    logic [SW-1:0] upd_sum = '0;
    logic [TW-1:0] upd_thresh = TW'(THR);
    logic [NT*WW-1:0] upd_weights = '0;
    logic wt_we;
    logic [NT*WW-1:0] wt_new;

    int n_chk = 0, n_bad = 0;
    logic last_we;
    logic [NT*WW-1:0] last_wt;

    always #10 clk = ~clk;

    corrector_chooser #(
        .NUM_TABLES(NT), .WEIGHT_W(WW), .SUM_W(SW), .THR_W(TW), .CHOOSER_W(CW)
    ) u0 (.*);

    function automatic logic [NT*WW-1:0] pack4(input int a, input int b, input int c, input int d);
        return {WW'(d), WW'(c), WW'(b), WW'(a)};
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // sum = bias + 4 with zero weights
    task automatic predict(input logic base, input int sum_val);
        @(negedge clk);
        pred_base_dir = base;
        pred_weights  = '0;
        pred_bias_sum = SW'(sum_val - NT);
        pred_thresh   = TW'(THR);
        #1;
    endtask

    task automatic update(input logic base, input int sum_val, input logic taken,
                          input logic [NT*WW-1:0] w);
        @(negedge clk);
        upd_valid = 1'b1; upd_base_dir = base; upd_sum = SW'(sum_val);
        upd_taken = taken; upd_weights = w; upd_thresh = TW'(THR);
        @(posedge clk); #1;
        last_we = wt_we; last_wt = wt_new;
        @(negedge clk); upd_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        predict(1'b0, 4);
        chk(int'(wt_we), 0, "R11 no write after reset");
        chk(int'(pred_final_dir), 0, "R11 zero chooser keeps base");
        chk(int'(pred_band), 0, "R4 band code low");
    endtask

    task automatic t_basic();
        predict(1'b1, 4);
        chk(int'(pred_final_dir), 1, "R2 agree");
        predict(1'b0, 0);
        chk(int'(pred_sc_dir), 1, "R1 zero sum is taken");
        predict(1'b0, -1);
        chk(int'(pred_sc_dir), 0, "R1 negative sum");
        predict(1'b0, 35);
        chk(int'(pred_band), 3, "R5 band code beyond");
        chk(int'(pred_final_dir), 1, "R5 beyond threshold overrides");
        predict(1'b0, 15);
        chk(int'(pred_band), 1, "R4 band code mid");
        predict(1'b0, 25);
        chk(int'(pred_band), 2, "R4 band code high");
        @(negedge clk);
        pred_bias_sum = SW'(10);
        pred_weights  = pack4(3, -2, 0, -1);
        #1;
        chk(int'($signed(pred_sum)), 14, "R6 weighted sum");
        pred_bias_sum = SW'(-20);
        pred_weights  = pack4(-5, -5, 1, 0);
        #1;
        chk(int'($signed(pred_sum)), -34, "R6 negative weighted sum");
    endtask

    task automatic t_bands();
        update(1'b0, 15, 1'b1, '0);
        predict(1'b0, 15);
        chk(int'(pred_final_dir), 1, "R4 mid band negative counter overrides");
        predict(1'b0, 5);
        chk(int'(pred_final_dir), 0, "R9 low band untouched");
        predict(1'b0, 25);
        chk(int'(pred_final_dir), 0, "R9 high band untouched");
        update(1'b0, 15, 1'b0, '0);
        predict(1'b0, 15);
        chk(int'(pred_final_dir), 0, "R9 base right moves counter up");
        update(1'b1, 15, 1'b1, '0);
        predict(1'b0, 15);
        chk(int'(pred_final_dir), 0, "R9 agreement leaves counter");
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 6; k++) update(1'b0, 25, 1'b1, '0);
        update(1'b0, 25, 1'b0, '0);
        predict(1'b0, 25);
        chk(int'(pred_final_dir), 1, "R10 negative limit holds");
        for (int k = 0; k < 5; k++) update(1'b0, 5, 1'b0, '0);
        update(1'b0, 5, 1'b1, '0);
        predict(1'b0, 5);
        chk(int'(pred_final_dir), 0, "R10 positive limit holds");
        for (int k = 0; k < 3; k++) update(1'b0, 5, 1'b1, '0);
        predict(1'b0, 5);
        chk(int'(pred_final_dir), 1, "R3 low band negative counter overrides");
        predict(1'b1, -5);
        chk(int'(pred_final_dir), 0, "R3 override toward not taken");
    endtask

    task automatic t_weights();
        update(1'b0, 5, 1'b1, pack4(3, -2, 31, -32));
        chk(int'(last_we), 1, "R7 small magnitude trains");
        chk(int'(last_wt), int'(pack4(4, -1, 31, -31)), "R8 train up saturates");
        update(1'b0, 5, 1'b0, pack4(3, -2, 31, -32));
        chk(int'(last_wt), int'(pack4(2, -3, 30, -32)), "R8 train down saturates");
        update(1'b1, 40, 1'b1, '0);
        chk(int'(last_we), 0, "R7 confident and right skips");
        update(1'b1, 40, 1'b0, '0);
        chk(int'(last_we), 1, "R7 confident but wrong trains");
        chk(int'(wt_we), 0, "R7 no write without strobe");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_bands();
        t_saturate();
        t_weights();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule